// File: doc/BRIEF.md
# Exclusive-Access Monitor for Two Requesters

This block lets two processors share one single-port word memory and build atomic read-modify-write sequences from a pair of accesses: an exclusive load, then a conditional exclusive store. An exclusive load reads a 64-bit word and arms a reservation for the requesting port on that word. A later exclusive store from the same port writes only if the reservation is still held. The reservation is lost when the other port has written the same word since the load. The store returns a status bit: 0 when the store completed, 1 when it was refused and memory was left untouched.

A fixed-priority arbiter grants one access per cycle. Port 0 always wins, and a stalled port sees its ready low and keeps its request asserted. Because the check and the write of an exclusive store happen inside the single granted cycle, no other access can land between them. Addresses are byte addresses. Memory is organised in 64-bit words, so the low three address bits select nothing. Responses arrive one cycle after the grant.

Top module: `xmon_top`

## Requirements
- R1: An exclusive load (we=1'b0, ex=1'b1) returns the addressed word on `rsp_rdata` and arms that port's reservation on the word.
- R2: An exclusive store (we=1'b1, ex=1'b1) from a port whose reservation covers the addressed word writes the word, and its response has `rsp_fail`=0.
- R3: A write by the other port (a plain store or a completed exclusive store) to a reserved word clears the reservation. The next exclusive store to that word then fails. Of two contenders racing for one word, exactly one store completes.
- R4: A failed exclusive store leaves memory unchanged and its response has `rsp_fail`=1.
- R5: Every exclusive store clears the storing port's own reservation, whether it completes or fails, so a second exclusive store without a new exclusive load fails.
- R6: An exclusive store to a word other than the reserved one fails.
- R7: The following leave a reservation intact: idle cycles, loads by either port, writes by the other port to other words, and plain stores by the holder itself.
- R8: Port 0 has fixed priority. `req_rdy[0]` is always 1, and `req_rdy[1]` is 0 whenever `req_vld[0]` is 1. Exactly one request is served per cycle. Its response (`rsp_vld` for that port) appears on the next clock edge.
- R9: Word index is `addr[ADDR_W-1:3]`. Addresses differing only in bits [2:0] name the same word, and addresses 8 apart name neighbouring, distinct words.
- R10: Reset (synchronous, active-low `rst_n`) clears both reservations, zeroes memory and holds `rsp_vld` at 0. An exclusive store right after reset fails.
- R11: A plain store (we=1'b1, ex=1'b0) always writes and reports `rsp_fail`=0. A plain load (we=1'b0, ex=1'b0) returns the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | NP | Request valid, one bit per port |
| req_addr | input | NP x ADDR_W | Byte address per port |
| req_we | input | NP | 1 = store, 0 = load |
| req_ex | input | NP | 1 = exclusive access |
| req_wdata | input | NP x DATA_W | Store data per port |
| req_rdy | output | NP | Request accepted this cycle |
| rsp_vld | output | NP | Response for that port this cycle |
| rsp_rdata | output | DATA_W | Word read by the answered load |
| rsp_fail | output | NP | Exclusive store refused (1) |

## Verification
The bench targets the races where a reservation should die or survive. Both ports load-reserve the same word and then both try to store. A design that failed to clear the loser's reservation on the winner's write would let both stores complete. One that cleared on any write, or on the holder's own plain store, would refuse legitimate stores. A second exclusive store without a new load exposes a monitor that forgets to clear its own reservation. Sub-word address offsets and neighbouring words expose a design that compares byte addresses rather than word indices.

// File: rtl/xmon_pkg.sv
// Shared constants and access encoding for the exclusive-access monitor.
// Assumes 64-bit words on byte addresses (3 offset bits).
package xmon_pkg;
    localparam int BYTE_OFS_W = 3;

    // Access kind, encoded as {exclusive, write}
    typedef enum logic [1:0] {
        ACC_LD  = 2'b00,
        ACC_ST  = 2'b01,
        ACC_LDX = 2'b10,
        ACC_STX = 2'b11
    } acc_e;

    // Width of a port pointer, never below one bit
    function automatic int ptr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xmon_arb.sv
// Fixed-priority arbiter: lower port index wins, one grant per cycle.
// Assumes requesters hold valid until they see ready.
module xmon_arb #(
    parameter int NP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] vld,
    output logic [NP-1:0] rdy,
    output logic [NP-1:0] gnt
);
    // Ready for port i when no higher-priority port requests
    for (genvar i = 0; i < NP; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign rdy[i] = 1'b1;
        end else begin : g_low
            assign rdy[i] = ~|vld[i-1:0];
        end
    end

    assign gnt = vld & rdy;

    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
endmodule

// File: rtl/xmon_resv.sv
// Reservation tracker for one port: holds a valid flag and a word index.
// Assumes at most one of arm/drop is set per cycle (one grant per cycle).
module xmon_resv #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             drop,
    input  logic             snoop_wr,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             hit
);
    logic             held;
    logic [IDX_W-1:0] held_idx;

    // Arm on exclusive load, clear on own exclusive store or foreign write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= 1'b0;
            held_idx <= '0;
        end else if (arm) begin
            held     <= 1'b1;
            held_idx <= cur_idx;
        end else if (drop || (snoop_wr && held_idx == cur_idx)) begin
            held     <= 1'b0;
        end
    end

    assign hit = held && (held_idx == cur_idx);

    // R1
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> held);
    // R5
    own_store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !arm) |=> !held);
    // R3
    foreign_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_wr && hit && !arm) |=> !held);
    // R7
    no_spurious_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !held) |=> !held);
endmodule

// File: rtl/xmon_mem.sv
// Single-port word memory: asynchronous read, synchronous write, reset to zero.
// Assumes WORDS is small enough to live in flops.
module xmon_mem #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] cells [WORDS];

    // Clear on reset, otherwise write the granted store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) cells[w] <= '0;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];

    // R11
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cells[$past(idx)] == $past(wdata));
endmodule

// File: rtl/xmon_top.sv
// Exclusive-access monitor for NP ports over a single-port word memory.
// One access is granted per cycle; exclusive-store check and write share
// that cycle, so they are atomic. Responses are registered (1-cycle latency).
module xmon_top
    import xmon_pkg::*;
#(
    parameter int NP     = 2,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NP-1:0]                req_vld,
    input  logic [NP-1:0][ADDR_W-1:0]    req_addr,
    input  logic [NP-1:0]                req_we,
    input  logic [NP-1:0]                req_ex,
    input  logic [NP-1:0][DATA_W-1:0]    req_wdata,
    output logic [NP-1:0]                req_rdy,
    output logic [NP-1:0]                rsp_vld,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic [NP-1:0]                rsp_fail
);
    localparam int IDX_W = ADDR_W - BYTE_OFS_W;
    localparam int PW    = ptr_w(NP);

    logic [NP-1:0]     gnt;
    logic              g_any;
    logic [PW-1:0]     g_port;
    logic [ADDR_W-1:0] g_addr;
    logic [DATA_W-1:0] g_wdata;
    acc_e              g_acc;
    logic [IDX_W-1:0]  g_idx;
    logic [NP-1:0]     hit;
    logic              s_ok;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd;
    logic              unused_ofs;

    xmon_arb #(.NP(NP)) u_arb (
        .clk(clk), .rst_n(rst_n), .vld(req_vld), .rdy(req_rdy), .gnt(gnt)
    );

    // Mux the granted request onto the shared access path
    always_comb begin
        g_any   = 1'b0;
        g_port  = '0;
        g_addr  = '0;
        g_wdata = '0;
        g_acc   = ACC_LD;
        for (int i = 0; i < NP; i++) begin
            if (gnt[i]) begin
                g_any   = 1'b1;
                g_port  = PW'(i);
                g_addr  = req_addr[i];
                g_wdata = req_wdata[i];
                g_acc   = acc_e'({req_ex[i], req_we[i]});
            end
        end
    end

    assign g_idx      = g_addr[ADDR_W-1:BYTE_OFS_W];
    assign unused_ofs = ^g_addr[BYTE_OFS_W-1:0];
    assign s_ok       = hit[g_port];
    assign mem_we     = g_any && ((g_acc == ACC_ST) || (g_acc == ACC_STX && s_ok));

    // One reservation tracker per port
    for (genvar i = 0; i < NP; i++) begin : g_port_resv
        xmon_resv #(.IDX_W(IDX_W)) u_resv (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (gnt[i] && g_acc == ACC_LDX),
            .drop     (gnt[i] && g_acc == ACC_STX),
            .snoop_wr (mem_we && !gnt[i]),
            .cur_idx  (g_idx),
            .hit      (hit[i])
        );

        // R8
        grant_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |=> rsp_vld[i]);
        // R4
        fail_only_on_xstore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_fail[i] |-> (rsp_vld[i] && $past(req_we[i] && req_ex[i])));
    end

    xmon_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .idx(g_idx),
        .wdata(g_wdata), .rdata(mem_rd)
    );

    // Register the response for the granted port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= '0;
            rsp_fail  <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_vld   <= gnt;
            rsp_fail  <= gnt & {NP{g_acc == ACC_STX && !s_ok}};
            if (g_any) rsp_rdata <= mem_rd;
        end
    end

    // R8
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_vld));
endmodule

// File: tb/xmon_top_test.sv
`timescale 1ns/1ps
// Bench for xmon_top: behavioural reference model compared every clock.
module xmon_top_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        vld = '0;
    logic [1:0][6:0]   addr = '0;
    logic [1:0]        we = '0;
    logic [1:0]        ex = '0;
    logic [1:0][63:0]  wd = '0;
    logic [1:0]        rdy;
    logic [1:0]        rsp_vld;
    logic [63:0]       rsp_rdata;
    logic [1:0]        rsp_fail;

    int total = 0;
    int bad = 0;
    int winners = 0;
    bit done = 0;

    logic [63:0] mm [16];
    int          rsv [2];

    xmon_top uut (
        .clk(clk), .rst_n(rst_n), .req_vld(vld), .req_addr(addr),
        .req_we(we), .req_ex(ex), .req_wdata(wd), .req_rdy(rdy),
        .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int p, input bit w, input bit x,
                       input int a, input logic [63:0] d);
        vld[p]  = 1'b1;
        we[p]   = w;
        ex[p]   = x;
        addr[p] = 7'(a);
        wd[p]   = d;
    endtask

    // One clock: check ready, predict, advance, compare response
    task automatic step(input string tag);
        int          w;
        logic [1:0]  ev;
        logic [1:0]  ef;
        logic [63:0] ed;
        bit          is_ld;
        bit          is_stx;
        #1;
        chk(tag, "rdy", 64'(rdy), 64'({~vld[0], 1'b1}));
        w = -1;
        if (vld[0]) w = 0;
        else if (vld[1]) w = 1;
        ev = '0; ef = '0; ed = '0; is_ld = 0; is_stx = 0;
        if (w >= 0) begin
            int  a;
            bit  ok;
            a = int'(addr[w]) >> 3;
            ev[w] = 1'b1;
            ed = mm[a];
            is_ld = !we[w];
            is_stx = we[w] && ex[w];
            if (we[w]) begin
                ok = !ex[w] || (rsv[w] == a);
                if (ex[w]) rsv[w] = -1;
                if (ok) begin
                    mm[a] = wd[w];
                    if (rsv[1-w] == a) rsv[1-w] = -1;
                end else begin
                    ef[w] = 1'b1;
                end
            end else if (ex[w]) begin
                rsv[w] = a;
            end
        end
        @(negedge clk);
        if (w >= 0) vld[w] = 1'b0;
        chk(tag, "rsp_vld", 64'(rsp_vld), 64'(ev));
        chk(tag, "rsp_fail", 64'(rsp_fail), 64'(ef));
        if (is_ld) chk(tag, "rsp_rdata", rsp_rdata, ed);
        if (is_stx && !rsp_fail[w]) winners++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mm[i] = '0;
        rsv[0] = -1; rsv[1] = -1;
        repeat (3) @(negedge clk);
        // R10: no responses during reset
        chk("R10", "rsp_vld in reset", 64'(rsp_vld), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: exclusive store right after reset fails, memory zero
        put(0, 1, 1, 'h00, 64'hAAAA); step("R10");
        put(1, 0, 0, 'h00, 0);        step("R10");

        // R11: plain store and load
        put(0, 1, 0, 'h08, 64'h1111_2222_3333_4444); step("R11");
        put(1, 0, 0, 'h08, 0);                       step("R11");

        // R1 / R2: exclusive pair completes
        put(0, 0, 1, 'h08, 0);         step("R1");
        put(0, 1, 1, 'h08, 64'h55);    step("R2");
        put(0, 0, 0, 'h08, 0);         step("R2");

        // R3 / R4: foreign plain store breaks the reservation
        put(1, 0, 1, 'h10, 0);         step("R3");
        put(0, 1, 0, 'h10, 64'h77);    step("R3");
        put(1, 1, 1, 'h10, 64'h99);    step("R4");
        put(1, 0, 0, 'h10, 0);         step("R4");

        // R5: second exclusive store without reload fails
        put(0, 0, 1, 'h18, 0);         step("R5");
        put(0, 1, 1, 'h18, 64'h1);     step("R5");
        put(0, 1, 1, 'h18, 64'h2);     step("R5");

        // R6: exclusive store to another word fails
        put(1, 0, 1, 'h20, 0);         step("R6");
        put(1, 1, 1, 'h28, 64'h3);     step("R6");
        put(1, 0, 0, 'h28, 0);         step("R6");

        // R7: idle, foreign loads, foreign write elsewhere, own plain store
        put(0, 0, 1, 'h30, 0);         step("R7");
        step("R7"); step("R7");
        put(1, 0, 0, 'h30, 0);         step("R7");
        put(1, 1, 0, 'h38, 64'hBEEF);  step("R7");
        put(0, 1, 0, 'h30, 64'h44);    step("R7");
        put(0, 1, 1, 'h30, 64'h45);    step("R7");

        // R9: sub-word offsets alias, neighbour word independent
        put(1, 0, 1, 'h41, 0);         step("R9");
        put(0, 1, 0, 'h48, 64'h6);     step("R9");
        put(1, 1, 1, 'h47, 64'h7);     step("R9");
        put(0, 0, 0, 'h40, 0);         step("R9");

        // R8: simultaneous requests, port 1 stalls one cycle
        put(0, 1, 0, 'h50, 64'hA0);
        put(1, 0, 0, 'h50, 0);         step("R8");
        step("R8");

        // R3: atomic swap race, exactly one completes
        winners = 0;
        put(1, 0, 1, 'h58, 0);         step("R3");
        put(0, 0, 1, 'h58, 0);         step("R3");
        put(0, 1, 1, 'h58, 64'hB0);
        put(1, 1, 1, 'h58, 64'hC0);    step("R3");
        step("R3");
        put(0, 0, 0, 'h58, 0);         step("R3");
        chk("R3", "swap winners", 64'(winners), 64'd1);

        // R3: spin-lock race on word 0x60, then release and retry
        winners = 0;
        put(0, 0, 1, 'h60, 0);
        put(1, 0, 1, 'h60, 0);         step("R3");
        step("R3");
        put(0, 1, 1, 'h60, 64'h1);
        put(1, 1, 1, 'h60, 64'h1);     step("R3");
        step("R3");
        chk("R3", "lock winners", 64'(winners), 64'd1);
        put(0, 1, 0, 'h60, 64'h0);     step("R3");
        put(1, 0, 1, 'h60, 0);         step("R3");
        put(1, 1, 1, 'h60, 64'h1);     step("R3");
        chk("R3", "lock retry winners", 64'(winners), 64'd2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule